// File: doc/BRIEF.md
# Butterfly Load/Store Index Generator

This block sits in the address path of a memory-based, constant-geometry real-valued FFT engine of `N = 2^N_LOG2` points. For every computation cycle it states which element index each processing-element operand is fetched from and which element index each result goes back to. There are `2^P_LOG2` processing elements, and each one takes eight operands, so one cycle yields `8·2^P_LOG2` load indices and the same number of store indices. A later stage turns these indices into bank and row addresses.

The caller supplies the per-stage cycle count `cyc_i` and the stage number `stage_i`. Inside the block, each PE number `k` is joined to the count to form a combined counter `C = cyc_i·2^P_LOG2 + k`, which is `N_LOG2−3` bits wide. The stage number picks a bit ordering. In the middle stages, a per-PE test on `C` separates cycles that shuffle only complex data (type I) from cycles that shuffle mixed real and complex data (type II). In the second-to-last stage, cycles with a non-zero `C` pair symmetric indices, so that the spectrum comes out in natural order. All indices are registered and change together.

Top module: `rfft_ix_gen`

## Requirements
- R1: While `rst` is high at a rising edge, both index buses read zero after that edge.
- R2: Both buses are registered. The result for the inputs present at a rising edge appears after that edge, and it holds unchanged until the next edge, whatever the inputs do in between. Lane `L = 8k + i` occupies bits `[L·N_LOG2 +: N_LOG2]`. Its slot is `i = {i2,i1,i0}`.
- R3: In stage 1, the load index (MSB first) is `{i0, i1, C, i2}`.
- R4: In stage 1, the store index is `{i1, C, i2, i0}`.
- R5: In stages 2 to `N_LOG2−2`, a PE's cycle is type I when the low `s−2` bits of its `C` are all zero. Every other cycle is type II. In stage 2, every cycle is type I.
- R6: For a type I cycle, the load index is `{C[top], i1, C[top−1:0], i2, i0}` and the store index is `{C, i1, i2, i0}`.
- R7: For a type II cycle, the load index is `{C[top], i0, C[top−1:0], i2, i1}` and the store index is `{C, i2, i1, i0}`.
- R8: In stage `N_LOG2−1` with `C = 0`, the load index is `{C, i2, i0, i1}` when `i2 = 1` and `{C, i}` otherwise. The store index is `{C, i}`.
- R9: In stage `N_LOG2−1` with `C ≠ 0`, let `w = floor(log2 C)` and `q = C − 2^w`. The load index is `2^(w+3)` plus one of four terms, chosen by `i0` and `i2`: `i1+2q` when both are 0; `2^(w+2)−1−(1−i1)−2q` when only `i2` is 1; `2^(w+2)+i1+2q` when only `i0` is 1; and `2^(w+3)−1−(1−i1)−2q` when both are 1. The store index is `2^(w+3)` plus one of four terms, chosen by `i1` and `i2`, with `i0` in the place of `i1`: `i0+2q` when both are 0; `2^(w+2)−1−(1−i0)−2q` when only `i2` is 1; `2^(w+3)−1−(1−i0)−2q` when only `i1` is 1; and `2^(w+2)+i0+2q` when both are 1.
- R10: In stage `N_LOG2`, the load index is `{C, i}` and the store index equals the load index.
- R11: For stage 0 (the input/output pass) and any stage above `N_LOG2`, the load and store indices are both `{C, i}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | N_LOG2−3−P_LOG2 | Cycle count within the current stage |
| stage_i | input | $clog2(N_LOG2+2) | Stage number, where 0 is the I/O pass |
| ld_idx_o | output | 8·2^P_LOG2·N_LOG2 | Operand load indices, one per lane |
| st_idx_o | output | 8·2^P_LOG2·N_LOG2 | Result store indices, one per lane |

## Verification
PEs share a cycle but each has its own `C`, so two different orderings can appear on the buses in the same cycle. In a middle stage with `s ≥ 3`, PE 0 can be type I while PE 1, whose `C` is odd, is type II. In stage `N_LOG2−1` at `cyc_i = 0`, PE 0 takes the `C = 0` ordering while PE 1 takes the symmetric-pair formula. The bench sweeps every stage across every cycle count, so both mixed cycles arise on their own. It judges each lane separately against a behavioural model that derives `C` from the lane position, so a lane that picked up a neighbour's decision fails under its own requirement tag.

// File: rtl/rfft_ix_pkg.sv
package rfft_ix_pkg;

  // Per-PE ordering selected for one computation cycle
  typedef enum logic [2:0] {
    MODE_IO    = 3'd0,
    MODE_FIRST = 3'd1,
    MODE_MIDA  = 3'd2,
    MODE_MIDB  = 3'd3,
    MODE_PAIR  = 3'd4,
    MODE_LAST  = 3'd5
  } ix_mode_t;

  localparam int unsigned SLOTS_PER_PE = 8;
  localparam int unsigned LOGW         = 6;

endpackage

// File: rtl/rfft_ix_mode.sv
module rfft_ix_mode
  import rfft_ix_pkg::*;
#(
  parameter int unsigned N_LOG2 = 7,
  parameter int unsigned SW     = 4,
  localparam int unsigned CW    = N_LOG2 - 3
) (
  input  logic [SW-1:0]   stage,
  input  logic [CW-1:0]   cnt,
  output ix_mode_t        mode,
  output logic [LOGW-1:0] wlog,
  output logic [CW-1:0]   kres
);

  logic [31:0] low_mask;
  logic        type_one;

  // type I when the low (s-2) bits of C are clear
  always_comb begin
    low_mask = (32'd1 << (32'(stage) - 32'd2)) - 32'd1;
    type_one = ((32'(cnt) & low_mask) == 32'd0);
  end

  always_comb begin
    if (32'(stage) == 32'd1)
      mode = MODE_FIRST;
    else if (32'(stage) >= 32'd2 && 32'(stage) <= N_LOG2 - 2)
      mode = type_one ? MODE_MIDA : MODE_MIDB;
    else if (32'(stage) == N_LOG2 - 1)
      mode = MODE_PAIR;
    else if (32'(stage) == N_LOG2)
      mode = MODE_LAST;
    else
      mode = MODE_IO;
  end

  // floor(log2 C) and the residue below the leading one
  always_comb begin
    wlog = '0;
    for (int j = 0; j < CW; j++)
      if (cnt[j]) wlog = LOGW'(j);
    kres = cnt & ~(CW'(1) << wlog);
  end

endmodule

// File: rtl/rfft_ix_slot.sv
module rfft_ix_slot
  import rfft_ix_pkg::*;
#(
  parameter int unsigned N_LOG2 = 7,
  parameter int unsigned SLOT   = 0,
  localparam int unsigned CW    = N_LOG2 - 3
) (
  input  ix_mode_t          mode,
  input  logic [CW-1:0]     cnt,
  input  logic [LOGW-1:0]   wlog,
  input  logic [CW-1:0]     kres,
  output logic [N_LOG2-1:0] ld_idx,
  output logic [N_LOG2-1:0] st_idx
);

  localparam int unsigned A0 = SLOT % 2;
  localparam int unsigned A1 = (SLOT / 2) % 2;
  localparam int unsigned A2 = (SLOT / 4) % 2;
  localparam logic B0 = 1'(A0);
  localparam logic B1 = 1'(A1);
  localparam logic B2 = 1'(A2);

  logic [31:0] two_q, p2, p3, ld_pair, st_pair;

  // symmetric pairing terms of the second-to-last stage
  always_comb begin
    two_q = 32'(kres) << 1;
    p2    = 32'd1 << (32'(wlog) + 32'd2);
    p3    = 32'd1 << (32'(wlog) + 32'd3);
    if (B0)
      ld_pair = B2 ? (p3 - 32'd1 - (32'd1 - A1) - two_q) : (p2 + A1 + two_q);
    else
      ld_pair = B2 ? (p2 - 32'd1 - (32'd1 - A1) - two_q) : (A1 + two_q);
    if (B1)
      st_pair = B2 ? (p2 + A0 + two_q) : (p3 - 32'd1 - (32'd1 - A0) - two_q);
    else
      st_pair = B2 ? (p2 - 32'd1 - (32'd1 - A0) - two_q) : (A0 + two_q);
    ld_pair = ld_pair + p3;
    st_pair = st_pair + p3;
  end

  always_comb begin
    case (mode)
      MODE_FIRST: begin
        ld_idx = {B0, B1, cnt, B2};
        st_idx = {B1, cnt, B2, B0};
      end
      MODE_MIDA: begin
        ld_idx = {cnt[CW-1], B1, cnt[CW-2:0], B2, B0};
        st_idx = {cnt, B1, B2, B0};
      end
      MODE_MIDB: begin
        ld_idx = {cnt[CW-1], B0, cnt[CW-2:0], B2, B1};
        st_idx = {cnt, B2, B1, B0};
      end
      MODE_PAIR: begin
        if (cnt == '0) begin
          ld_idx = B2 ? {cnt, B2, B0, B1} : {cnt, B2, B1, B0};
          st_idx = {cnt, B2, B1, B0};
        end else begin
          ld_idx = N_LOG2'(ld_pair);
          st_idx = N_LOG2'(st_pair);
        end
      end
      default: begin
        ld_idx = {cnt, B2, B1, B0};
        st_idx = {cnt, B2, B1, B0};
      end
    endcase
  end

endmodule

// File: rtl/rfft_ix_gen.sv
module rfft_ix_gen
  import rfft_ix_pkg::*;
#(
  parameter int unsigned N_LOG2 = 7,
  parameter int unsigned P_LOG2 = 1,
  localparam int unsigned CW    = N_LOG2 - 3,
  localparam int unsigned CYW   = CW - P_LOG2,
  localparam int unsigned PES   = 1 << P_LOG2,
  localparam int unsigned LANES = SLOTS_PER_PE * PES,
  localparam int unsigned SW    = $clog2(N_LOG2 + 2),
  localparam int unsigned BW    = LANES * N_LOG2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CYW-1:0] cyc_i,
  input  logic [SW-1:0]  stage_i,
  output logic [BW-1:0]  ld_idx_o,
  output logic [BW-1:0]  st_idx_o
);

  logic [BW-1:0] ld_next, st_next;

  for (genvar pe = 0; pe < PES; pe++) begin : g_pe
    logic [CW-1:0]   cval;
    ix_mode_t        mode;
    logic [LOGW-1:0] wlog;
    logic [CW-1:0]   kres;

    assign cval = (CW'(cyc_i) << P_LOG2) | CW'(pe);

    rfft_ix_mode #(.N_LOG2(N_LOG2), .SW(SW)) i_mode (
      .stage (stage_i),
      .cnt   (cval),
      .mode  (mode),
      .wlog  (wlog),
      .kres  (kres)
    );

    for (genvar sl = 0; sl < SLOTS_PER_PE; sl++) begin : g_slot
      localparam int unsigned LANE = pe * SLOTS_PER_PE + sl;
      rfft_ix_slot #(.N_LOG2(N_LOG2), .SLOT(sl)) i_slot (
        .mode   (mode),
        .cnt    (cval),
        .wlog   (wlog),
        .kres   (kres),
        .ld_idx (ld_next[LANE*N_LOG2 +: N_LOG2]),
        .st_idx (st_next[LANE*N_LOG2 +: N_LOG2])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_idx_o <= '0;
      st_idx_o <= '0;
    end else begin
      ld_idx_o <= ld_next;
      st_idx_o <= st_next;
    end
  end

  // R1: reset clears both buses
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ld_idx_o == '0 && st_idx_o == '0));

  // R10: last stage mirrors load into store
  p_last_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && 32'($past(stage_i)) == N_LOG2) |-> (st_idx_o == ld_idx_o));

  // R3: stage-1 load of lane 0 carries the counter of the previous cycle
  p_first_count_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && 32'($past(stage_i)) == 32'd1)
      |-> (ld_idx_o[N_LOG2-3:1] == (CW'($past(cyc_i)) << P_LOG2)));

  // R6: type I at stage 2 stores PE 0 slot 0 at {C,000}
  p_mid_store_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && 32'($past(stage_i)) == 32'd2)
      |-> (st_idx_o[N_LOG2-1:0] == {CW'($past(cyc_i)) << P_LOG2, 3'b000}));

  // R8: zero counter in the pairing stage swaps the low slots of i2 lanes
  p_pair_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && 32'($past(stage_i)) == N_LOG2 - 1 && $past(cyc_i) == '0)
      |-> (ld_idx_o[5*N_LOG2 +: N_LOG2] == N_LOG2'(6) &&
           st_idx_o[5*N_LOG2 +: N_LOG2] == N_LOG2'(5)));

endmodule

// File: tb/test_rfft_ix_gen.sv
`timescale 1ns/1ps
module test_rfft_ix_gen;

  localparam int N    = 7;
  localparam int P    = 1;
  localparam int CW   = N - 3;
  localparam int CYW  = CW - P;
  localparam int PES  = 1 << P;
  localparam int LN   = 8 * PES;
  localparam int SW   = $clog2(N + 2);
  localparam int BW   = LN * N;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [CYW-1:0] cyc_i = '0;
  logic [SW-1:0]  stage_i = '0;
  logic [BW-1:0]  ld_idx_o, st_idx_o;

  int checks = 0;
  int errors = 0;
  int ticks  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rfft_ix_gen #(.N_LOG2(N), .P_LOG2(P)) i_rfft_ix_gen (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stage_i(stage_i),
    .ld_idx_o(ld_idx_o), .st_idx_o(st_idx_o)
  );

  function automatic int ilog2(int v);
    int r = 0;
    while ((v >> (r + 1)) != 0) r++;
    return r;
  endfunction

  // behavioural model: returns load (st=0) or store (st=1) index
  function automatic int model(int s, int c, int i, bit st);
    int i0 = i % 2, i1 = (i / 2) % 2, i2 = i / 4;
    int nat = c * 8 + i;
    int r;
    if (s == 1)
      r = st ? (i1 * (1 << (N - 1)) + c * 4 + i2 * 2 + i0)
             : (i0 * (1 << (N - 1)) + i1 * (1 << (N - 2)) + c * 2 + i2);
    else if (s >= 2 && s <= N - 2) begin
      bit t1 = (c % (1 << (s - 2))) == 0;
      int top = (c >> (N - 4)) % 2, rest = c % (1 << (N - 4));
      if (st) r = c * 8 + (t1 ? (i1 * 4 + i2 * 2 + i0) : (i2 * 4 + i1 * 2 + i0));
      else    r = top * (1 << (N - 1)) + (t1 ? i1 : i0) * (1 << (N - 2))
                  + rest * 4 + i2 * 2 + (t1 ? i0 : i1);
    end else if (s == N - 1) begin
      if (c == 0)
        r = (!st && i2 == 1) ? (4 + i0 * 2 + i1) : i;
      else begin
        int w = ilog2(c), q = c - (1 << w);
        int a = 1 << (w + 2), b = 1 << (w + 3);
        if (!st)
          r = b + (1 - i0) * (i2 * (a - 1 - (1 - i1) - 2 * q) + (1 - i2) * (i1 + 2 * q))
                + i0 * (i2 * (b - 1 - (1 - i1) - 2 * q) + (1 - i2) * (a + i1 + 2 * q));
        else
          r = b + (1 - i1) * (i2 * (a - 1 - (1 - i0) - 2 * q) + (1 - i2) * (i0 + 2 * q))
                + i1 * ((1 - i2) * (b - 1 - (1 - i0) - 2 * q) + i2 * (a + i0 + 2 * q));
      end
    end else
      r = nat;
    return r % (1 << N);
  endfunction

  function automatic string tag(int s, int c, bit st);
    if (s == 1) return st ? "R4" : "R3";
    if (s >= 2 && s <= N - 2) return ((c % (1 << (s - 2))) == 0) ? "R5 R6" : "R5 R7";
    if (s == N - 1) return (c == 0) ? "R8" : "R9";
    if (s == N) return "R10";
    return "R11";
  endfunction

  task automatic chk(string req, int lane, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s lane %0d: actual %0d expected %0d", req, lane, act, exp);
    end
  endtask

  // compare every lane against the model for inputs (s, cy)
  task automatic compare_all(int s, int cy, string override);
    for (int ln = 0; ln < LN; ln++) begin
      int k = ln / 8, sl = ln % 8;
      int c = cy * PES + k;
      int ea = model(s, c, sl, 1'b0), eb = model(s, c, sl, 1'b1);
      chk(override != "" ? override : tag(s, c, 1'b0), ln,
          int'(ld_idx_o[ln*N +: N]), ea);
      chk(override != "" ? override : tag(s, c, 1'b1), ln,
          int'(st_idx_o[ln*N +: N]), eb);
      if (s == N) chk("R10", ln, int'(st_idx_o[ln*N +: N]), int'(ld_idx_o[ln*N +: N]));
    end
  endtask

  task automatic check_zero(string req);
    chk(req, -1, int'(ld_idx_o != '0), 0);
    chk(req, -1, int'(st_idx_o != '0), 0);
  endtask

  // watchdog
  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", ticks);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int ps, pc;
    repeat (3) @(negedge clk);
    check_zero("R1");
    @(negedge clk);
    rst = 1'b0;
    ps = 0; pc = 0;
    stage_i = SW'(ps); cyc_i = CYW'(pc);
    // sweep stages 0..N+1 and the top stage code, every cycle count
    for (int st = 0; st <= N + 2; st++) begin
      int sv = (st == N + 2) ? (1 << SW) - 1 : st;
      for (int cy = 0; cy < (1 << CYW); cy++) begin
        @(negedge clk);
        compare_all(ps, pc, "");
        stage_i = SW'(sv); cyc_i = CYW'(cy);
        // R2: outputs hold until the next edge despite new inputs
        #1;
        compare_all(ps, pc, "R2");
        ps = sv; pc = cy;
      end
    end
    @(negedge clk);
    compare_all(ps, pc, "");
    // R1: reset in mid-run with live inputs
    stage_i = SW'(3); cyc_i = CYW'(5);
    rst = 1'b1;
    @(negedge clk);
    check_zero("R1");
    rst = 1'b0;
    @(negedge clk);
    compare_all(3, 5, "");
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule